// File: doc/BRIEF.md
# Ancillary Data Packet Formatter

This block places one ancillary data packet into a 10-bit parallel video word stream during horizontal blanking. Software-side logic hands it the packet body on a 9-bit bus: either a secondary identifier followed by user words, or, in numbered mode, only the user words, with the block supplying a running block number in the second header slot. The block stores the body. When blanking begins, it puts in front of the body a flag sequence (three words for component video, one for composite), a data identifier and a data count. It then appends a 9-bit checksum, and it generates bit 9 of every header and payload word.

At the first blanking word after a body has been stored, the block compares the total packet length with the number of blanking words still left. If the packet fits, it replaces the video words with the packet, starting at that word. If it does not fit, it discards the packet, leaves the video untouched and raises a sticky error bit, which clears when it is read. Outside a packet, video words reach the output one clock later and are not changed.

Top module: `anc_packet_formatter`

## Requirements
- R1: When no packet is being inserted, `vid_out` equals the `vid_in` of the previous clock.
- R2: The packet opens with the flag words 000h, 3FFh, 3FFh when `flag_short` is 0, and with the single word 3FCh when `flag_short` is 1.
- R3: The identifier word follows the flag. Its bits 7:4 are the parameter `DID_UPPER` (default Fh) and its bits 3:0 are `did_nib`. Bit 8 is the even parity of bits 7:0 and bit 9 is the inverse of bit 8, so nibble Fh gives 2FFh and nibble Dh gives 1FDh.
- R4: The word after the identifier is the block number (with parity as in R3) when `num_mode` is 1. When `num_mode` is 0 it is the first stored payload word, with bit 9 = NOT bit 8.
- R5: The next word is the data count. It carries the number of user words (all stored words when `num_mode` is 1, all but the first otherwise), with parity as in R3.
- R6: The user words follow in arrival order. Bits 8:0 are as supplied and bit 9 is the inverse of bit 8.
- R7: The last packet word is the checksum. Bits 8:0 are the modulo-512 sum of bits 8:0 of every word from the identifier through the last user word, and bit 9 is the inverse of bit 8.
- R8: The block number is 1 after reset. It advances by one after each numbered packet that is inserted and goes from 255 back to 1. Dropped packets and packets with `num_mode` at 0 leave it unchanged.
- R9: A stored packet starts at the first clock in which `space_left` is non-zero. It is inserted if its total word count is at most `space_left`. Otherwise it is discarded and no video word changes.
- R10: `err_flag` is 0 after reset and becomes 1 the clock after a discard. A clock with `err_rd` high clears it, unless a discard happens in the same clock, in which case the flag stays 1.
- R11: `pld_en` goes high one clock before the first payload word and stays high through the clock before the last. `busy` is high from the start of collection until the packet is inserted or discarded. While a stored packet waits, `pld_en` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_in | input | 10 | Video word input |
| space_left | input | SPACE_W | Blanking words left including the current one, 0 outside blanking |
| flag_short | input | 1 | 1 selects the one-word composite flag |
| num_mode | input | 1 | 1 inserts the block number and treats all payload as user words |
| did_nib | input | 4 | Low nibble of the data identifier |
| pld_en | input | 1 | Payload enable, leads the data by one clock |
| pld_data | input | 9 | Payload word |
| err_rd | input | 1 | Reads and clears the error bit |
| vid_out | output | 10 | Video word output, one clock latency |
| busy | output | 1 | A packet is being collected or waits for insertion |
| err_flag | output | 1 | Sticky packet-discard error |

## Verification
The packet index, the block-number counter and the checksum accumulator are the internal state that can go wrong. A bad index shows at once as a misplaced header or user word at `vid_out`, in the first packet. A wrong checksum value appears in the last word of that same packet. A bad block-number counter shows in the header of the next numbered packet, and only a run across 255 packets shows a wrong wrap value. A wrong fit decision shows either as packet words where video was expected or as a missing `err_flag`. The sweep compares every output word against a packet that the bench builds word by word, across both flag styles, both numbering modes, several lengths and the exact-fit and one-short boundaries.

// File: rtl/anc_fmt_pkg.sv
package anc_fmt_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_COLLECT,
      ST_PEND,
      ST_EMIT
   } fmt_state_t;

   // 8-bit value to a 10-bit word: even parity in bit 8, its inverse in bit 9
   function automatic logic [9:0] par_word(input logic [7:0] d);
      logic p;
      p = ^d;
      return {~p, p, d};
   endfunction

   // 9-bit value to a 10-bit word: bit 9 is the inverse of bit 8
   function automatic logic [9:0] inv_word(input logic [8:0] w);
      return {~w[8], w};
   endfunction

   localparam logic [9:0] FLAG_SHORT_WORD = 10'h3FC;
   localparam logic [9:0] FLAG_LONG_HEAD  = 10'h000;
   localparam logic [9:0] FLAG_LONG_TAIL  = 10'h3FF;

endpackage

// File: rtl/anc_payload_buf.sv
module anc_payload_buf #(
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_clr,
   input  logic          wr_en,
   input  logic [8:0]    wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [8:0]    rd_data,
   output logic [CW-1:0] count
);

   logic [8:0] mem [DEPTH];

   if (DEPTH < 2) begin : g_bad_depth
      $error("anc_payload_buf: DEPTH must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (wr_en && !wr_clr && (count < CW'(DEPTH))) begin
         mem[count[AW-1:0]] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || wr_clr) begin
         count <= '0;
      end else if (wr_en && (count < CW'(DEPTH))) begin
         count <= count + CW'(1);
      end
   end

   assign rd_data = mem[rd_addr];

   // R11: the stored body cannot change while nothing is being written
   a_r11_body_frozen : assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !wr_clr) |=> $stable(count));

endmodule

// File: rtl/anc_err_flag.sv
module anc_err_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic rd,
   output logic flag
);

   always_ff @(posedge clk) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (rd)  flag <= 1'b0;
   end

   a_r10_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag);

   a_r10_read_clears : assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !set) |=> !flag);

endmodule

// File: rtl/anc_pkt_seq.sv
module anc_pkt_seq
   import anc_fmt_pkg::*;
#(
   parameter int          MAX_UDW   = 255,
   parameter int          SPACE_W   = 12,
   parameter logic [3:0]  DID_UPPER = 4'hF,
   localparam int DEPTH = MAX_UDW + 1,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1),
   localparam int LW    = $clog2(MAX_UDW + 9),
   localparam int MW    = (LW > SPACE_W) ? LW : SPACE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pld_en,
   input  logic               flag_short,
   input  logic               num_mode,
   input  logic [3:0]         did_nib,
   input  logic [SPACE_W-1:0] space_left,
   input  logic [CW-1:0]      buf_count,
   input  logic [8:0]         buf_data,
   output logic               wr_en,
   output logic               wr_clr,
   output logic [AW-1:0]      rd_addr,
   output logic               emit,
   output logic               in_flag,
   output logic [9:0]         emit_word,
   output logic               drop,
   output logic               busy
);

   fmt_state_t    state;
   logic [LW-1:0] idx;
   logic [7:0]    dbn;
   logic [8:0]    cs_acc;

   logic [CW-1:0] n_udw;
   logic [CW-1:0] store_lim;
   logic [1:0]    flag_n;
   logic [LW-1:0] tot_len;
   logic [LW-1:0] cur_idx;
   logic [LW-1:0] rel;
   logic [LW-1:0] body_end;
   logic [LW-1:0] addr_full;
   logic          start;
   logic          fits;
   logic          last_word;
   logic          in_sum;

   // ---- packet geometry ----
   assign n_udw     = num_mode ? buf_count : buf_count - CW'(1);
   assign store_lim = num_mode ? CW'(MAX_UDW) : CW'(MAX_UDW + 1);
   assign flag_n    = flag_short ? 2'd1 : 2'd3;
   assign tot_len   = LW'(flag_n) + LW'(4) + LW'(n_udw);
   assign body_end  = LW'(3) + LW'(n_udw);

   // ---- fit decision ----
   assign start = (state == ST_PEND) && (space_left != '0);
   assign fits  = MW'(tot_len) <= MW'(space_left);
   assign drop  = start && !fits;
   assign emit  = (state == ST_EMIT) || (start && fits);

   // ---- word position ----
   assign cur_idx   = (state == ST_EMIT) ? idx : '0;
   assign in_flag   = cur_idx < LW'(flag_n);
   assign rel       = cur_idx - LW'(flag_n);
   assign last_word = cur_idx == (tot_len - LW'(1));
   assign in_sum    = !in_flag && (rel < body_end);

   assign addr_full = (rel == LW'(1)) ? '0
                    : (rel - LW'(3) + (num_mode ? LW'(0) : LW'(1)));
   assign rd_addr   = addr_full[AW-1:0];

   // ---- word mux ----
   always_comb begin
      emit_word = '0;
      if (in_flag) begin
         if (flag_short)          emit_word = FLAG_SHORT_WORD;
         else if (cur_idx == '0)  emit_word = FLAG_LONG_HEAD;
         else                     emit_word = FLAG_LONG_TAIL;
      end else if (rel == LW'(0)) begin
         emit_word = par_word({DID_UPPER, did_nib});
      end else if (rel == LW'(1)) begin
         emit_word = num_mode ? par_word(dbn) : inv_word(buf_data);
      end else if (rel == LW'(2)) begin
         emit_word = par_word(8'(n_udw));
      end else if (rel < body_end) begin
         emit_word = inv_word(buf_data);
      end else begin
         emit_word = inv_word(cs_acc);
      end
   end

   // ---- buffer control ----
   assign wr_clr = (state == ST_IDLE);
   assign wr_en  = (state == ST_COLLECT) && (buf_count < store_lim);
   assign busy   = (state != ST_IDLE);

   // ---- state, index, checksum, block number ----
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         idx    <= '0;
         cs_acc <= '0;
         dbn    <= 8'd1;
      end else begin
         if (emit && in_sum) begin
            if (rel == LW'(0)) cs_acc <= emit_word[8:0];
            else               cs_acc <= cs_acc + emit_word[8:0];
         end
         unique case (state)
            ST_IDLE: begin
               if (pld_en) state <= ST_COLLECT;
            end
            ST_COLLECT: begin
               if (!pld_en) state <= ST_PEND;
            end
            ST_PEND: begin
               if (drop) begin
                  state <= ST_IDLE;
               end else if (start) begin
                  state <= ST_EMIT;
                  idx   <= LW'(1);
               end
            end
            ST_EMIT: begin
               idx <= idx + LW'(1);
               if (last_word) begin
                  state <= ST_IDLE;
                  if (num_mode) dbn <= (dbn == 8'd255) ? 8'd1 : dbn + 8'd1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   a_r8_dbn_nonzero : assert property (@(posedge clk) disable iff (!rst_n)
      dbn != 8'd0);

   a_r8_dbn_step : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dbn) |-> (dbn == (($past(dbn) == 8'd255) ? 8'd1 : $past(dbn) + 8'd1)));

   a_r11_pend_ignores_en : assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PEND && !start) |=> (state == ST_PEND));

endmodule

// File: rtl/anc_packet_formatter.sv
module anc_packet_formatter #(
   parameter int         MAX_UDW   = 255,
   parameter int         SPACE_W   = 12,
   parameter logic [3:0] DID_UPPER = 4'hF,
   localparam int DEPTH = MAX_UDW + 1,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [9:0]         vid_in,
   input  logic [SPACE_W-1:0] space_left,
   input  logic               flag_short,
   input  logic               num_mode,
   input  logic [3:0]         did_nib,
   input  logic               pld_en,
   input  logic [8:0]         pld_data,
   input  logic               err_rd,
   output logic [9:0]         vid_out,
   output logic               busy,
   output logic               err_flag
);

   if (MAX_UDW < 1 || MAX_UDW > 255) begin : g_bad_udw
      $error("anc_packet_formatter: MAX_UDW must lie in 1..255");
   end
   if (SPACE_W < 3) begin : g_bad_space
      $error("anc_packet_formatter: SPACE_W too narrow for a packet");
   end

   logic          wr_en, wr_clr;
   logic [AW-1:0] rd_addr;
   logic [8:0]    rd_data;
   logic [CW-1:0] count;
   logic          emit, in_flag, drop;
   logic [9:0]    emit_word;

   anc_payload_buf #(.DEPTH(DEPTH)) i_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_clr  (wr_clr),
      .wr_en   (wr_en),
      .wr_data (pld_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .count   (count)
   );

   anc_pkt_seq #(
      .MAX_UDW   (MAX_UDW),
      .SPACE_W   (SPACE_W),
      .DID_UPPER (DID_UPPER)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .pld_en     (pld_en),
      .flag_short (flag_short),
      .num_mode   (num_mode),
      .did_nib    (did_nib),
      .space_left (space_left),
      .buf_count  (count),
      .buf_data   (rd_data),
      .wr_en      (wr_en),
      .wr_clr     (wr_clr),
      .rd_addr    (rd_addr),
      .emit       (emit),
      .in_flag    (in_flag),
      .emit_word  (emit_word),
      .drop       (drop),
      .busy       (busy)
   );

   anc_err_flag i_err (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (drop),
      .rd    (err_rd),
      .flag  (err_flag)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) vid_out <= '0;
      else        vid_out <= emit ? emit_word : vid_in;
   end

   a_r1_passthrough : assert property (@(posedge clk) disable iff (!rst_n)
      !emit |=> (vid_out == $past(vid_in)));

   a_r9_drop_leaves_video : assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> (vid_out == $past(vid_in)));

   a_r6_bit9_inverse : assert property (@(posedge clk) disable iff (!rst_n)
      (emit && !in_flag) |=> (vid_out[9] != vid_out[8]));

endmodule

// File: tb/test_anc_packet_formatter.sv
module test_anc_packet_formatter;

   localparam int CLK_PERIOD = 10;
   localparam int SPACE_W    = 12;

   logic               clk = 1'b0;
   logic               rst_n;
   logic [9:0]         vid_in;
   logic [SPACE_W-1:0] space_left;
   logic               flag_short, num_mode;
   logic [3:0]         did_nib;
   logic               pld_en;
   logic [8:0]         pld_data;
   logic               err_rd;
   logic [9:0]         vid_out;
   logic               busy, err_flag;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic [8:0] pl [0:255];
   int         pl_n;
   logic [9:0] exp_w [0:299];
   int         exp_len;
   int         exp_flag_n;
   int         exp_dbn = 1;

   always #(CLK_PERIOD/2) clk = ~clk;

   anc_packet_formatter #(.SPACE_W(SPACE_W)) i_anc_packet_formatter (
      .clk(clk), .rst_n(rst_n), .vid_in(vid_in), .space_left(space_left),
      .flag_short(flag_short), .num_mode(num_mode), .did_nib(did_nib),
      .pld_en(pld_en), .pld_data(pld_data), .err_rd(err_rd),
      .vid_out(vid_out), .busy(busy), .err_flag(err_flag));

   function automatic logic [9:0] pw(input logic [7:0] d);
      return {~(^d), ^d, d};
   endfunction

   task automatic check(input string req, input logic [9:0] act, input logic [9:0] expv);
      n_checks++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual %03h expected %03h", req, act, expv);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic send(input int cnt, input int seed);
      pl_n = cnt;
      for (int i = 0; i < cnt; i++) pl[i] = 9'((seed * 37 + i * 113 + 5) % 512);
      pld_en = 1'b1; pld_data = '0;
      tick();
      for (int i = 0; i < cnt; i++) begin
         pld_data = pl[i];
         pld_en   = (i < cnt - 1);
         tick();
      end
      pld_en = 1'b0;
   endtask

   task automatic build();
      int n, k, sum;
      exp_flag_n = flag_short ? 1 : 3;
      k = 0;
      if (flag_short) exp_w[k++] = 10'h3FC;
      else begin exp_w[k++] = 10'h000; exp_w[k++] = 10'h3FF; exp_w[k++] = 10'h3FF; end
      n = num_mode ? pl_n : pl_n - 1;
      exp_w[k++] = pw({4'hF, did_nib});
      if (num_mode) exp_w[k++] = pw(8'(exp_dbn));
      else          exp_w[k++] = {~pl[0][8], pl[0]};
      exp_w[k++] = pw(8'(n));
      for (int i = 0; i < n; i++) begin
         logic [8:0] w;
         w = pl[num_mode ? i : i + 1];
         exp_w[k++] = {~w[8], w};
      end
      sum = 0;
      for (int i = exp_flag_n; i < k; i++) sum += int'(exp_w[i][8:0]);
      exp_w[k] = {~sum[8], sum[8:0]};
      k++;
      exp_len = k;
   endtask

   function automatic string tag_of(input int j);
      int r;
      if (j < exp_flag_n) return "R2 flag";
      r = j - exp_flag_n;
      if (r == 0) return "R3 identifier";
      if (r == 1) return num_mode ? "R8 block number" : "R4 second id";
      if (r == 2) return "R5 count";
      if (j == exp_len - 1) return "R7 checksum";
      return "R6 user word";
   endfunction

   task automatic blank_run(input int space, input bit rd_first);
      bit fit;
      build();
      fit = (exp_len <= space);
      for (int j = 0; j < space + 2; j++) begin
         logic [9:0] v;
         v = 10'((j * 71 + 19) % 1024);
         vid_in     = v;
         space_left = (j < space) ? SPACE_W'(space - j) : '0;
         err_rd     = rd_first && (j == 0);
         tick();
         if (fit && j < exp_len) check(tag_of(j), vid_out, exp_w[j]);
         else check(fit ? "R1 after packet" : "R9 dropped, video kept", vid_out, v);
         if (j == 0 && !fit) check("R10 set wins over read", 10'(err_flag), 10'd1);
      end
      err_rd = 1'b0;
      check("R11 busy clear", 10'(busy), 10'd0);
      if (fit && num_mode) exp_dbn = (exp_dbn == 255) ? 1 : exp_dbn + 1;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; vid_in = '0; space_left = '0; flag_short = 1'b0;
      num_mode = 1'b0; did_nib = 4'hF; pld_en = 1'b0; pld_data = '0; err_rd = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      check("R10 reset err", 10'(err_flag), 10'd0);
      check("R11 reset busy", 10'(busy), 10'd0);
      check("R1 reset out", vid_out, 10'd0);

      // R1: plain pass-through
      for (int j = 0; j < 6; j++) begin
         logic [9:0] v;
         v = 10'(j * 201 + 3);
         vid_in = v; tick();
         check("R1 pass", vid_out, v);
      end

      // Sweep flag style, numbering mode, length; space exact or larger
      for (int fs = 0; fs < 2; fs++)
         for (int nm = 0; nm < 2; nm++)
            for (int li = 0; li < 5; li++) begin
               int cnt;
               cnt = (li == 0) ? 1 : (li == 1) ? 2 : (li == 2) ? 3 : (li == 3) ? 7 : 12;
               flag_short = fs[0]; num_mode = nm[0];
               did_nib = 4'((li * 5 + fs * 3 + nm) % 16);
               send(cnt, li + fs * 7 + nm * 13);
               check("R11 busy while pending", 10'(busy), 10'd1);
               build();
               blank_run(exp_len + (li % 3), 1'b0);
            end

      // R9/R10: one word short is dropped; read clears the flag
      flag_short = 1'b0; num_mode = 1'b1; did_nib = 4'hD;
      send(4, 99);
      build();
      blank_run(exp_len - 1, 1'b0);
      check("R10 flag after drop", 10'(err_flag), 10'd1);
      err_rd = 1'b1; tick(); err_rd = 1'b0;
      check("R10 cleared by read", 10'(err_flag), 10'd0);

      // R10: discard in the same clock as a read keeps the flag
      flag_short = 1'b1;
      send(5, 41);
      build();
      blank_run(exp_len - 1, 1'b1);
      err_rd = 1'b1; tick(); err_rd = 1'b0;
      check("R10 cleared", 10'(err_flag), 10'd0);

      // R8: numbered packet after a drop still uses the same number
      send(2, 17);
      build();
      blank_run(exp_len, 1'b0);

      // R11: payload enable ignored while a packet waits
      flag_short = 1'b0; num_mode = 1'b0; did_nib = 4'h9;
      send(6, 55);
      for (int j = 0; j < 4; j++) begin
         pld_en = 1'b1; pld_data = 9'(j * 99 + 1); tick();
      end
      pld_en = 1'b0; tick();
      blank_run(40, 1'b0);

      // Longest packet: 255 user words, exact fit
      num_mode = 1'b1; did_nib = 4'hB;
      send(255, 3);
      build();
      check("R5 max count", exp_w[exp_flag_n + 2], pw(8'd255));
      blank_run(exp_len, 1'b0);

      // R8: run the block number through 255 back to 1
      flag_short = 1'b1; num_mode = 1'b1; did_nib = 4'hF;
      for (int p = 0; p < 260; p++) begin
         send(1, p);
         build();
         blank_run(exp_len, 1'b0);
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule